// File: doc/BRIEF.md
# Signature-Based Flow State Table

This block keeps track of which flows are live and where each one's state record lives. A flow key is hashed once. The low hash bits pick a bucket, and the top hash bits form a short signature. Each bucket holds a few signatures and a valid mask in fast on-chip registers, one signature per slot. Flows whose hash lands in the same bucket are told apart by comparing signatures there. The bulk per-flow state sits in a separate large memory that the block does not model. The block only produces the record address, built from the bucket number and the slot.

Each command is a lookup, an insert or a delete, carried on a valid/ready handshake. Every accepted command returns exactly one response, two clock edges later and in command order. The response says whether the signature was found and gives the record address. It also raises an exception when an insert finds its bucket full, so that a slow path can take that flow.

Top module: `sft_table`

## Requirements
- R1: While reset is asserted and on the first sampling after it is released, `rsp_valid` is 0. `cmd_ready` is 1 once reset has been released. Every slot of the table starts empty.
- R2: The hash is h = (key × 0x9E3779B1) mod 2^32. The bucket index is h[IDX_W-1:0] and the signature is h[31:16]. The record address is index×4 + slot, so the index occupies `rsp_addr[IDX_W+1:2]` and the slot occupies `rsp_addr[1:0]`.
- R3: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. Its response is presented with `rsp_valid`=1 after the second rising edge following acceptance. There is exactly one response per command, in order, and back-to-back commands are allowed.
- R4: A lookup (op 0) whose signature is valid in its bucket returns `rsp_hit`=1 and that slot's address. Otherwise it returns `rsp_hit`=0 and `rsp_addr`=0.
- R5: An insert (op 1) of an absent signature into a bucket with free slots stores it in the lowest-numbered free slot. It returns `rsp_hit`=0, `rsp_exc`=0 and that slot's address.
- R6: An insert whose signature is already valid in the bucket returns `rsp_hit`=1 and the existing slot's address, and allocates nothing.
- R7: An insert of an absent signature into a bucket whose four slots are all valid returns `rsp_exc`=1, `rsp_hit`=0 and `rsp_addr`=0, and leaves the table unchanged.
- R8: A delete (op 2) of a present signature returns `rsp_hit`=1 with the freed slot's address and clears that slot. The slot then misses on lookup and is reused by the next insert into that bucket.
- R9: A delete of an absent signature returns `rsp_hit`=0 and `rsp_addr`=0 and changes nothing.
- R10: A lookup, and the reserved op 3 (which behaves as a lookup), never change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 lookup, 1 insert, 2 delete, 3 treated as lookup |
| cmd_key | input | KEY_W (32) | Flow key |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_hit | output | 1 | Signature was found in its bucket |
| rsp_exc | output | 1 | Insert overflowed a full bucket |
| rsp_addr | output | IDX_W+2 (6) | State record address, index×4 + slot |

## Verification
The bench fills one bucket with four distinct signatures and then inserts a fifth. A design that ignored the full mask would overwrite a live slot instead of raising the exception. It also deletes a middle slot and inserts again. A design with a wrong free-slot priority would place the new flow above the hole rather than in it. Repeated inserts and double deletes target designs that allocate duplicate slots or disturb the table on a miss. Streams of back-to-back commands hitting the same bucket expose a design that reads a bucket before the previous command's write has landed.

// File: rtl/sft_pkg.sv
// Shared definitions for the signature flow table.
// Assumes: command opcodes are two bits wide; code 3 is reserved and acts as a lookup.
package sft_pkg;
    typedef enum logic [1:0] {
        SFT_LOOKUP = 2'd0,
        SFT_INSERT = 2'd1,
        SFT_DELETE = 2'd2,
        SFT_RSVD   = 2'd3
    } sft_op_e;

    localparam logic [31:0] SFT_HASH_MULT = 32'h9E37_79B1;
endpackage

// File: rtl/sft_hash.sv
// Multiplicative hash of a flow key into a bucket index and a signature.
// Assumes: IDX_W + SIG_W <= 32, so the index and signature bits never overlap.
module sft_hash #(
    parameter int KEY_W = 32,
    parameter int IDX_W = 4,
    parameter int SIG_W = 16
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx,
    output logic [SIG_W-1:0] sig
);
    localparam int HASH_W = 32;

    logic [HASH_W-1:0] key_w;
    logic [HASH_W-1:0] hval;

    // Fit the key into the hash width and multiply by the odd constant.
    always_comb begin
        key_w = HASH_W'(key);
        hval  = key_w * sft_pkg::SFT_HASH_MULT;
        idx   = hval[IDX_W-1:0];
        sig   = hval[HASH_W-1 -: SIG_W];
    end
endmodule

// File: rtl/sft_match.sv
// Compares a probe signature with every slot of one bucket.
// Finds the matching slot and the lowest free slot.
// Assumes: at most one valid slot holds a given signature (the insert logic keeps this true).
module sft_match #(
    parameter int WAYS  = 4,
    parameter int SIG_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chk_en,
    input  logic [WAYS*SIG_W-1:0]   slot_sig,
    input  logic [WAYS-1:0]         slot_vld,
    input  logic [SIG_W-1:0]        probe,
    output logic                    hit,
    output logic [$clog2(WAYS)-1:0] hit_slot,
    output logic                    has_free,
    output logic [$clog2(WAYS)-1:0] free_slot
);
    localparam int SLOT_W = $clog2(WAYS);

    logic [WAYS-1:0] match_vec;

    // One comparator per slot.
    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            assign match_vec[g] = slot_vld[g] && (slot_sig[g*SIG_W +: SIG_W] == probe);
        end
    endgenerate

    // Encode the matching slot and the lowest free slot.
    always_comb begin
        hit       = |match_vec;
        has_free  = ~&slot_vld;
        hit_slot  = '0;
        free_slot = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_slot = SLOT_W'(i);
            if (!slot_vld[i]) free_slot = SLOT_W'(i);
        end
    end

    // R6
    sig_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> $onehot0(match_vec));
endmodule

// File: rtl/sft_store.sv
// Bucket storage: WAYS signatures and a valid mask per bucket.
// It has one combinational read port and one write port that sets or clears a single slot.
// Assumes: only the valid masks need reset; a signature is meaningless while its valid bit is 0.
module sft_store #(
    parameter int IDX_W = 4,
    parameter int WAYS  = 4,
    parameter int SIG_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [WAYS*SIG_W-1:0]   rd_sig,
    output logic [WAYS-1:0]         rd_vld,
    input  logic                    we,
    input  logic                    wr_set,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [$clog2(WAYS)-1:0] wr_slot,
    input  logic [SIG_W-1:0]        wr_sig
);
    localparam int NBKT = 1 << IDX_W;

    logic [WAYS*SIG_W-1:0] sig_mem [NBKT];
    logic [WAYS-1:0]       vld_mem [NBKT];

    // Read the addressed bucket.
    always_comb begin
        rd_sig = sig_mem[rd_idx];
        rd_vld = vld_mem[rd_idx];
    end

    // Clear all valid masks on reset; otherwise set or clear one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBKT; b++) vld_mem[b] <= '0;
        end else if (we) begin
            vld_mem[wr_idx][wr_slot] <= wr_set;
        end
    end

    // Write the signature on allocation.
    always_ff @(posedge clk) begin
        if (we && wr_set) sig_mem[wr_idx][wr_slot*SIG_W +: SIG_W] <= wr_sig;
    end

    // R5 R8
    slot_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (vld_mem[wr_idx][wr_slot] != wr_set));
endmodule

// File: rtl/sft_table.sv
// Signature-based flow table top.
// Stage 1 registers the hashed command. Stage 2 reads the bucket, compares signatures,
// updates the bucket and registers the response.
// Assumes: the bulk state memory lives outside; only its record address is produced here.
module sft_table #(
    parameter int KEY_W = 32,
    parameter int IDX_W = 4,
    parameter int SIG_W = 16,
    parameter int WAYS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [1:0]              cmd_op,
    input  logic [KEY_W-1:0]        cmd_key,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_exc,
    output logic [IDX_W+$clog2(WAYS)-1:0] rsp_addr
);
    import sft_pkg::*;

    localparam int SLOT_W = $clog2(WAYS);
    localparam int ADDR_W = IDX_W + SLOT_W;

    logic              accept;
    logic [IDX_W-1:0]  h_idx;
    logic [SIG_W-1:0]  h_sig;

    logic              s1_valid;
    sft_op_e           s1_op;
    logic [IDX_W-1:0]  s1_idx;
    logic [SIG_W-1:0]  s1_sig;

    logic [WAYS*SIG_W-1:0] b_sig;
    logic [WAYS-1:0]       b_vld;
    logic                  m_hit;
    logic [SLOT_W-1:0]     m_slot;
    logic                  m_free;
    logic [SLOT_W-1:0]     m_free_slot;

    logic                  we;
    logic                  wr_set;
    logic [SLOT_W-1:0]     wr_slot;
    logic                  n_hit;
    logic                  n_exc;
    logic [ADDR_W-1:0]     n_addr;

    assign accept = cmd_valid && cmd_ready;

    sft_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .SIG_W(SIG_W)) u_hash (
        .key(cmd_key), .idx(h_idx), .sig(h_sig)
    );

    // Ready is held low during reset and rises afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_ready <= 1'b0;
        else        cmd_ready <= 1'b1;
    end

    // Stage 1: capture the hashed command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= SFT_LOOKUP;
            s1_idx   <= '0;
            s1_sig   <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_op  <= sft_op_e'(cmd_op);
                s1_idx <= h_idx;
                s1_sig <= h_sig;
            end
        end
    end

    sft_store #(.IDX_W(IDX_W), .WAYS(WAYS), .SIG_W(SIG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(s1_idx), .rd_sig(b_sig), .rd_vld(b_vld),
        .we(we), .wr_set(wr_set), .wr_idx(s1_idx), .wr_slot(wr_slot), .wr_sig(s1_sig)
    );

    sft_match #(.WAYS(WAYS), .SIG_W(SIG_W)) u_match (
        .clk(clk), .rst_n(rst_n), .chk_en(s1_valid),
        .slot_sig(b_sig), .slot_vld(b_vld), .probe(s1_sig),
        .hit(m_hit), .hit_slot(m_slot), .has_free(m_free), .free_slot(m_free_slot)
    );

    // Stage 2 decision: the bucket update and the response fields.
    always_comb begin
        we      = 1'b0;
        wr_set  = 1'b0;
        wr_slot = m_slot;
        n_hit   = 1'b0;
        n_exc   = 1'b0;
        n_addr  = '0;
        if (s1_valid) begin
            unique case (s1_op)
                SFT_INSERT: begin
                    if (m_hit) begin
                        n_hit  = 1'b1;
                        n_addr = {s1_idx, m_slot};
                    end else if (m_free) begin
                        we      = 1'b1;
                        wr_set  = 1'b1;
                        wr_slot = m_free_slot;
                        n_addr  = {s1_idx, m_free_slot};
                    end else begin
                        n_exc = 1'b1;
                    end
                end
                SFT_DELETE: begin
                    if (m_hit) begin
                        we     = 1'b1;
                        n_hit  = 1'b1;
                        n_addr = {s1_idx, m_slot};
                    end
                end
                default: begin
                    if (m_hit) begin
                        n_hit  = 1'b1;
                        n_addr = {s1_idx, m_slot};
                    end
                end
            endcase
        end
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_exc   <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_hit   <= n_hit;
            rsp_exc   <= n_exc;
            rsp_addr  <= n_addr;
        end
    end

    // R3
    rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(accept, 2));

    // R7
    exc_only_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc) |-> ($past(s1_op) == SFT_INSERT && !rsp_hit));

    // R10
    lookup_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_op == SFT_LOOKUP || s1_op == SFT_RSVD)) |-> !we);

    // R7
    full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_set) |-> !(&b_vld));
endmodule

// File: tb/sft_table_bench.sv
module sft_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBKT = 16;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_key = '0;
    logic        rsp_valid, rsp_hit, rsp_exc;
    logic [5:0]  rsp_addr;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_sig [NBKT][WAYS];
    logic        m_vld [NBKT][WAYS];

    // two-deep expectation pipe
    logic        p0_v = 0, p1_v = 0;
    logic        p0_h, p1_h, p0_e, p1_e;
    logic [5:0]  p0_a, p1_a;
    string       p0_r, p1_r;

    logic [31:0] pool [40];
    logic [31:0] dk [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    sft_table u_sft_table (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_key(cmd_key), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_exc(rsp_exc), .rsp_addr(rsp_addr)
    );

    function automatic logic [31:0] hsh(input logic [31:0] k);
        return k * 32'h9E3779B1;
    endfunction

    function automatic int bidx(input logic [31:0] k);
        logic [31:0] h = hsh(k);
        return int'(h[3:0]);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: apply one command in order, return the expected response.
    task automatic model(input logic [1:0] op, input logic [31:0] k,
                         output logic h, output logic e, output logic [5:0] a);
        logic [31:0] hv = hsh(k);
        int b = int'(hv[3:0]);
        int ms = -1, fs = -1;
        h = 0; e = 0; a = 0;
        for (int s = 0; s < WAYS; s++) begin
            if (m_vld[b][s] && m_sig[b][s] == hv[31:16] && ms < 0) ms = s;
            if (!m_vld[b][s] && fs < 0) fs = s;
        end
        if (op == 2'd1) begin
            if (ms >= 0) begin h = 1; a = 6'(b*4 + ms); end
            else if (fs >= 0) begin
                m_vld[b][fs] = 1; m_sig[b][fs] = hv[31:16]; a = 6'(b*4 + fs);
            end else e = 1;
        end else if (op == 2'd2) begin
            if (ms >= 0) begin h = 1; a = 6'(b*4 + ms); m_vld[b][ms] = 0; end
        end else if (ms >= 0) begin
            h = 1; a = 6'(b*4 + ms);
        end
    endtask

    // One cycle: check the response due now, then drive the next command.
    task automatic cyc(input logic v, input logic [1:0] op, input logic [31:0] k, input string req);
        @(negedge clk);
        check("R3", "rsp_valid", int'(rsp_valid), int'(p1_v));
        if (p1_v) begin
            check(p1_r, "rsp_hit", int'(rsp_hit), int'(p1_h));
            check(p1_r, "rsp_exc", int'(rsp_exc), int'(p1_e));
            check(p1_r, "rsp_addr", int'(rsp_addr), int'(p1_a));
        end
        p1_v = p0_v; p1_h = p0_h; p1_e = p0_e; p1_a = p0_a; p1_r = p0_r;
        p0_v = v; p0_r = req;
        if (v) model(op, k, p0_h, p0_e, p0_a);
        cmd_valid = v; cmd_op = op; cmd_key = k;
    endtask

    task automatic drain();
        cyc(0, 2'd0, 32'd0, "R3");
        cyc(0, 2'd0, 32'd0, "R3");
        cyc(0, 2'd0, 32'd0, "R3");
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        for (int b = 0; b < NBKT; b++)
            for (int s = 0; s < WAYS; s++) begin m_vld[b][s] = 0; m_sig[b][s] = '0; end

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cmd_ready", int'(cmd_ready), 1);
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);

        // R2: R1 empty table; R2 hash and address layout via lookups that must miss
        for (int i = 0; i < 40; i++) pool[i] = $urandom();
        for (int i = 0; i < 8; i++) cyc(1, 2'd0, pool[i], "R1");
        drain();

        // Five keys in bucket 5 with distinct signatures
        for (int n = 0; n < 5; n++) begin
            logic ok;
            logic [31:0] k;
            do begin
                k = $urandom();
                ok = (bidx(k) == 5);
                for (int j = 0; j < n; j++) if (hsh(dk[j]) >> 16 == hsh(k) >> 16) ok = 0;
            end while (!ok);
            dk[n] = k;
        end

        // R5 fill lowest slots, back to back; R2 address index*4+slot
        cyc(1, 2'd1, dk[0], "R5");
        cyc(1, 2'd1, dk[1], "R5");
        cyc(1, 2'd1, dk[2], "R2");
        cyc(1, 2'd1, dk[3], "R5");
        // R7 overflow
        cyc(1, 2'd1, dk[4], "R7");
        cyc(1, 2'd0, dk[4], "R7");
        // R6 re-insert existing
        cyc(1, 2'd1, dk[1], "R6");
        cyc(1, 2'd1, dk[1], "R6");
        // R4 lookup hit
        cyc(1, 2'd0, dk[2], "R4");
        // R10 reserved op acts as lookup
        cyc(1, 2'd3, dk[0], "R10");
        // R8 delete middle, R9 double delete
        cyc(1, 2'd2, dk[1], "R8");
        cyc(1, 2'd2, dk[1], "R9");
        cyc(1, 2'd0, dk[1], "R8");
        cyc(1, 2'd1, dk[4], "R8");
        cyc(1, 2'd0, dk[4], "R4");
        cyc(1, 2'd0, dk[3], "R10");
        drain();

        // Random mix over a small key pool (R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 800; i++) begin
            int r = int'($urandom_range(0, 9));
            logic [1:0] op = (r < 4) ? 2'd1 : (r < 7) ? 2'd0 : (r < 9) ? 2'd2 : 2'd3;
            logic v = ($urandom_range(0, 5) != 0);
            cyc(v, op, pool[$urandom_range(0, 39)], "R4");
        end
        drain();

        // R10 final sweep of lookups
        for (int i = 0; i < 40; i++) cyc(1, 2'd0, pool[i], "R10");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule